// File: doc/BRIEF.md
# Scoreboard Issue Hazard Controller

This block is the central bookkeeping unit of a small pipeline with three functional units: integer/load, floating add and floating multiply. Each unit can finish its work after any number of cycles, so results may come back out of order. One decoded instruction is offered per cycle, carrying a unit class, a destination register and two source registers, over eight architectural registers. The controller decides when the instruction may enter its unit. It then tells that unit when its operands are safe to read from the register file and when its result is safe to write back. Register values never travel through this block. Units signal the end of execution with a done strobe.

Every unit runs a four-state machine. IDLE moves to WAIT_OPS on the transition *issue*. WAIT_OPS moves to EXEC on *read operands*, which needs both sources free of pending writers. EXEC moves to WAIT_WR on *done*. WAIT_WR returns to IDLE on *write grant*. A register result table records, for each register, the unit that will write it.

There is no renaming and there is no forwarding. A destination conflict blocks issue, and a write is held back while an older instruction still has to read the old value. One register-file write port is shared. When several units want it, the lowest unit index gets it.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset all units are in IDLE and the register table is empty. `issue_stall`, `fu_read_go`, `fu_write_go` and `rf_we` are all low, and the first valid instruction issues without stalling.
- R2: An instruction whose unit is not in IDLE is not issued (structural hazard). `in_unit` codes: 0 integer/load, 1 floating add, 2 floating multiply.
- R3: An instruction whose destination register already has a pending writer in the table is not issued. This holds even if that writer is granted the write port in the same cycle.
- R4: `fu_read_go[u]` is high for exactly the cycle in which unit u is in WAIT_OPS with both sources free. At issue, a source counts as free when it has no pending writer, or when its pending writer is being granted the write port in that same cycle.
- R5: A unit in WAIT_WR is not granted the write port while any other unit in WAIT_OPS has that destination as a source that is free but not yet read.
- R6: At most one bit of `fu_write_go` is high. The lowest-index eligible unit wins. `rf_we` equals the OR of the grants, and `rf_waddr` is the winner's destination.
- R7: Issue is in order. `issue_stall` = `in_valid` and not issued. A stalled instruction must be held on the inputs by the source. Issue moves the unit to WAIT_OPS and marks its destination as pending.
- R8: There is no forwarding. A source that waits on a writer becomes free only at that writer's grant, so its read can happen no earlier than the next cycle.
- R9: `fu_done[u]` is acted on only in EXEC and is ignored in every other state. A write request starts the cycle after the done strobe, and a write grant returns the unit to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 2 | Unit class of the instruction |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| fu_done | input | 3 | Per-unit end of execution strobe |
| issue_stall | output | 1 | Instruction held, fetch must repeat it |
| fu_read_go | output | 3 | Per-unit operand read permission |
| fu_write_go | output | 3 | Per-unit result write permission |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write address |

## Verification
`issue_stall`, `fu_read_go`, `fu_write_go`, `rf_we` and `rf_waddr` are combinational from the unit states and the current inputs. They are therefore due in the same cycle as the stimulus that causes them. Every phase change takes effect one clock edge later. The earliest timings are:
- a read permission comes one cycle after issue;
- a write request comes one cycle after the done strobe;
- a waiting consumer reads one cycle after its producer's grant.

The bench drives inputs at the falling edge and samples one nanosecond later against a cycle model. The model advances exactly one phase step per rising edge, so every comparison falls inside the cycle in which the result is due.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        UNIT_IDLE     = 2'd0,
        UNIT_WAIT_OPS = 2'd1,
        UNIT_EXEC     = 2'd2,
        UNIT_WAIT_WR  = 2'd3
    } unit_state_e;

endpackage

// File: rtl/sb_unit_fsm.sv
module sb_unit_fsm
    import sb_pkg::*;
#(
    parameter int REG_W = 3,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [REG_W-1:0] issue_dst,
    input  logic [REG_W-1:0] issue_src1,
    input  logic [REG_W-1:0] issue_src2,
    input  logic             issue_qj_v,
    input  logic [TAG_W-1:0] issue_qj,
    input  logic             issue_qk_v,
    input  logic [TAG_W-1:0] issue_qk,
    input  logic             bcast_v,
    input  logic [TAG_W-1:0] bcast_tag,
    input  logic             ex_done,
    input  logic             wr_grant,
    output unit_state_e      state_o,
    output logic [REG_W-1:0] fi_o,
    output logic [REG_W-1:0] fj_o,
    output logic [REG_W-1:0] fk_o,
    output logic             rj_o,
    output logic             rk_o,
    output logic             read_go,
    output logic             wr_req
);

    unit_state_e      state_q, state_d;
    logic [REG_W-1:0] fi_q, fj_q, fk_q;
    logic [TAG_W-1:0] qj_q, qk_q;
    logic             qj_v_q, qk_v_q;
    logic             rj_q, rk_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UNIT_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_IDLE:     if (issue_en)     state_d = UNIT_WAIT_OPS;
            UNIT_WAIT_OPS: if (rj_q && rk_q) state_d = UNIT_EXEC;
            UNIT_EXEC:     if (ex_done)      state_d = UNIT_WAIT_WR;
            UNIT_WAIT_WR:  if (wr_grant)     state_d = UNIT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        read_go = (state_q == UNIT_WAIT_OPS) && rj_q && rk_q;
        wr_req  = (state_q == UNIT_WAIT_WR);
        state_o = state_q;
        fi_o    = fi_q;
        fj_o    = fj_q;
        fk_o    = fk_q;
        rj_o    = rj_q;
        rk_o    = rk_q;
    end

    // instruction fields and operand readiness
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi_q   <= '0;
            fj_q   <= '0;
            fk_q   <= '0;
            qj_q   <= '0;
            qk_q   <= '0;
            qj_v_q <= 1'b0;
            qk_v_q <= 1'b0;
            rj_q   <= 1'b0;
            rk_q   <= 1'b0;
        end else if (state_q == UNIT_IDLE && issue_en) begin
            fi_q   <= issue_dst;
            fj_q   <= issue_src1;
            fk_q   <= issue_src2;
            qj_q   <= issue_qj;
            qk_q   <= issue_qk;
            qj_v_q <= issue_qj_v;
            qk_v_q <= issue_qk_v;
            rj_q   <= !issue_qj_v;
            rk_q   <= !issue_qk_v;
        end else if (state_q == UNIT_WAIT_OPS) begin
            if (rj_q && rk_q) begin
                rj_q <= 1'b0;
                rk_q <= 1'b0;
            end else begin
                if (bcast_v && qj_v_q && qj_q == bcast_tag) begin
                    qj_v_q <= 1'b0;
                    rj_q   <= 1'b1;
                end
                if (bcast_v && qk_v_q && qk_q == bcast_tag) begin
                    qk_v_q <= 1'b0;
                    rk_q   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
    parameter int NUM_REG = 8,
    parameter int TAG_W   = 2,
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_en,
    input  logic [REG_W-1:0]                set_reg,
    input  logic [TAG_W-1:0]                set_tag,
    input  logic                            clr_en,
    input  logic [REG_W-1:0]                clr_reg,
    output logic [NUM_REG-1:0]              pend_v,
    output logic [NUM_REG-1:0][TAG_W-1:0]   pend_tag
);

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_v[r]   <= 1'b0;
                pend_tag[r] <= '0;
            end else if (set_en && set_reg == REG_W'(r)) begin
                pend_v[r]   <= 1'b1;
                pend_tag[r] <= set_tag;
            end else if (clr_en && clr_reg == REG_W'(r)) begin
                pend_v[r]   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sb_wr_arbiter.sv
module sb_wr_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic taken;

    always_comb begin
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = req[i] && !taken;
            taken    = taken | req[i];
        end
    end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_FU  = 3,
    parameter int NUM_REG = 8,
    localparam int REG_W  = $clog2(NUM_REG),
    localparam int TAG_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_unit,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    input  logic [NUM_FU-1:0] fu_done,
    output logic              issue_stall,
    output logic [NUM_FU-1:0] fu_read_go,
    output logic [NUM_FU-1:0] fu_write_go,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr
);

    unit_state_e                    unit_state [NUM_FU];
    logic [NUM_FU-1:0][REG_W-1:0]   fi_arr, fj_arr, fk_arr;
    logic [NUM_FU-1:0]              rj_vec, rk_vec, wait_ops_vec, busy_vec;
    logic [NUM_FU-1:0]              wr_req_vec, war_ok, issue_sel;
    logic [NUM_REG-1:0]             pend_v;
    logic [NUM_REG-1:0][TAG_W-1:0]  pend_tag;
    logic                           unit_known, unit_busy, issue_fire;
    logic                           src1_pend, src2_pend;
    logic [TAG_W-1:0]               bcast_tag;

    // unit selection and issue decision
    always_comb begin
        unit_known = 1'b0;
        unit_busy  = 1'b0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (in_unit == TAG_W'(u)) begin
                unit_known = 1'b1;
                unit_busy  = busy_vec[u];
            end
        end
        issue_fire  = in_valid && unit_known && !unit_busy && !pend_v[in_dst];
        issue_stall = in_valid && !issue_fire;
        for (int u = 0; u < NUM_FU; u++) begin
            issue_sel[u] = issue_fire && (in_unit == TAG_W'(u));
        end
    end

    // source pending at issue, freed by a same-cycle write
    always_comb begin
        src1_pend = pend_v[in_src1] && !(rf_we && rf_waddr == in_src1);
        src2_pend = pend_v[in_src2] && !(rf_we && rf_waddr == in_src2);
    end

    // write-after-read guard per unit
    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            war_ok[f] = 1'b1;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f && wait_ops_vec[g] &&
                    ((rj_vec[g] && fj_arr[g] == fi_arr[f]) ||
                     (rk_vec[g] && fk_arr[g] == fi_arr[f]))) begin
                    war_ok[f] = 1'b0;
                end
            end
        end
    end

    sb_wr_arbiter #(.N(NUM_FU)) u_arb (
        .req   (wr_req_vec & war_ok),
        .grant (fu_write_go)
    );

    // write port encode
    always_comb begin
        rf_we     = |fu_write_go;
        rf_waddr  = '0;
        bcast_tag = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (fu_write_go[u]) begin
                rf_waddr  = fi_arr[u];
                bcast_tag = TAG_W'(u);
            end
        end
    end

    sb_reg_status #(.NUM_REG(NUM_REG), .TAG_W(TAG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_fire),
        .set_reg  (in_dst),
        .set_tag  (in_unit),
        .clr_en   (rf_we),
        .clr_reg  (rf_waddr),
        .pend_v   (pend_v),
        .pend_tag (pend_tag)
    );

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        sb_unit_fsm #(.REG_W(REG_W), .TAG_W(TAG_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_en   (issue_sel[u]),
            .issue_dst  (in_dst),
            .issue_src1 (in_src1),
            .issue_src2 (in_src2),
            .issue_qj_v (src1_pend),
            .issue_qj   (pend_tag[in_src1]),
            .issue_qk_v (src2_pend),
            .issue_qk   (pend_tag[in_src2]),
            .bcast_v    (rf_we),
            .bcast_tag  (bcast_tag),
            .ex_done    (fu_done[u]),
            .wr_grant   (fu_write_go[u]),
            .state_o    (unit_state[u]),
            .fi_o       (fi_arr[u]),
            .fj_o       (fj_arr[u]),
            .fk_o       (fk_arr[u]),
            .rj_o       (rj_vec[u]),
            .rk_o       (rk_vec[u]),
            .read_go    (fu_read_go[u]),
            .wr_req     (wr_req_vec[u])
        );
        assign busy_vec[u]     = (unit_state[u] != UNIT_IDLE);
        assign wait_ops_vec[u] = (unit_state[u] == UNIT_WAIT_OPS);
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_FU = 3,
    parameter int REG_W  = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic                            issue_stall,
    input logic [NUM_FU-1:0]               fu_read_go,
    input logic [NUM_FU-1:0]               fu_write_go,
    input logic [NUM_FU-1:0]               wait_ops_vec,
    input logic [NUM_FU-1:0]               rj_vec,
    input logic [NUM_FU-1:0]               rk_vec,
    input logic [NUM_FU-1:0][REG_W-1:0]    fi_arr,
    input logic [NUM_FU-1:0][REG_W-1:0]    fj_arr,
    input logic [NUM_FU-1:0][REG_W-1:0]    fk_arr
);

    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_write_go));

    p_stall_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> in_valid);

    for (genvar f = 0; f < NUM_FU; f++) begin : g_f
        p_read_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fu_read_go[f] |=> !fu_read_go[f]);

        p_no_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
            fu_read_go[f] |=> !fu_write_go[f]);

        for (genvar g = 0; g < NUM_FU; g++) begin : g_g
            if (g != f) begin : g_pair
                p_war_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    fu_write_go[f] |-> !(wait_ops_vec[g] &&
                        ((rj_vec[g] && fj_arr[g] == fi_arr[f]) ||
                         (rk_vec[g] && fk_arr[g] == fi_arr[f]))));
            end
        end
    end

endmodule

bind scoreboard_ctrl sb_checker #(.NUM_FU(NUM_FU), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .issue_stall  (issue_stall),
    .fu_read_go   (fu_read_go),
    .fu_write_go  (fu_write_go),
    .wait_ops_vec (wait_ops_vec),
    .rj_vec       (rj_vec),
    .rk_vec       (rk_vec),
    .fi_arr       (fi_arr),
    .fj_arr       (fj_arr),
    .fk_arr       (fk_arr)
);

// File: tb/scoreboard_ctrl_tb.sv
`timescale 1ns/1ps
module scoreboard_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = '0;
    logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [2:0] fu_done = '0;
    logic       issue_stall;
    logic [2:0] fu_read_go, fu_write_go;
    logic       rf_we;
    logic [2:0] rf_waddr;

    always #4 clk = ~clk;

    scoreboard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .fu_done(fu_done),
        .issue_stall(issue_stall), .fu_read_go(fu_read_go),
        .fu_write_go(fu_write_go), .rf_we(rf_we), .rf_waddr(rf_waddr)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model state: 0 idle, 1 wait operands, 2 execute, 3 wait write
    int m_st[3], m_fi[3], m_fj[3], m_fk[3], m_qj[3], m_qk[3], lat[3], lat_max[3];
    bit m_qjv[3], m_qkv[3], m_rj[3], m_rk[3];
    bit m_pv[8];
    int m_pt[8];

    bit       e_stall, e_we, e_issue, war_blocked, multi_req;
    bit [2:0] e_rd, e_wr;
    int       e_waddr, e_win;
    int       stall_cause; // 2 busy, 3 destination pending

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit war_ok(int f);
        for (int g = 0; g < 3; g++)
            if (g != f && m_st[g] == 1 &&
                ((m_rj[g] && m_fj[g] == m_fi[f]) || (m_rk[g] && m_fk[g] == m_fi[f])))
                return 0;
        return 1;
    endfunction

    task automatic model_eval(bit v, int u, int d);
        int nreq;
        nreq = 0; war_blocked = 0; e_win = -1; e_wr = '0;
        for (int f = 0; f < 3; f++) begin
            e_rd[f] = (m_st[f] == 1) && m_rj[f] && m_rk[f];
            if (m_st[f] == 3) begin
                if (!war_ok(f)) war_blocked = 1;
                else begin
                    nreq++;
                    if (e_win < 0) e_win = f;
                end
            end
        end
        multi_req = (nreq > 1);
        if (e_win >= 0) e_wr[e_win] = 1'b1;
        e_we    = (e_win >= 0);
        e_waddr = e_we ? m_fi[e_win] : 0;
        stall_cause = 0;
        if (v && m_st[u] != 0) stall_cause = 2;
        else if (v && m_pv[d]) stall_cause = 3;
        e_issue = v && (stall_cause == 0);
        e_stall = v && !e_issue;
    endtask

    task automatic model_update(int u, int d, int s1, int s2, bit [2:0] done);
        for (int f = 0; f < 3; f++) begin
            case (m_st[f])
                1: begin
                    if (m_rj[f] && m_rk[f]) begin
                        m_rj[f] = 0; m_rk[f] = 0; m_st[f] = 2;
                        lat[f] = $urandom_range(lat_max[f], 0);
                    end else begin
                        if (e_we && m_qjv[f] && m_qj[f] == e_win) begin m_qjv[f] = 0; m_rj[f] = 1; end
                        if (e_we && m_qkv[f] && m_qk[f] == e_win) begin m_qkv[f] = 0; m_rk[f] = 1; end
                    end
                end
                2: begin
                    if (done[f]) m_st[f] = 3;
                    else if (lat[f] > 0) lat[f]--;
                end
                3: if (e_wr[f]) m_st[f] = 0;
                default: ;
            endcase
        end
        if (e_issue) begin
            bit p1, p2;
            p1 = m_pv[s1] && !(e_we && e_waddr == s1);
            p2 = m_pv[s2] && !(e_we && e_waddr == s2);
            m_st[u] = 1; m_fi[u] = d; m_fj[u] = s1; m_fk[u] = s2;
            m_qjv[u] = p1; m_qj[u] = m_pt[s1]; m_rj[u] = !p1;
            m_qkv[u] = p2; m_qk[u] = m_pt[s2]; m_rk[u] = !p2;
        end
        if (e_we) m_pv[e_waddr] = 0;
        if (e_issue) begin m_pv[d] = 1; m_pt[d] = u; end
    endtask

    // one clock cycle: drive at falling edge, compare 1 ns later, advance model
    task automatic step(bit v, int u, int d, int s1, int s2, output bit stalled);
        bit [2:0] done;
        string sreq, wreq;
        @(negedge clk);
        for (int f = 0; f < 3; f++) begin
            if (m_st[f] == 2) done[f] = (lat[f] == 0);
            else              done[f] = ($urandom_range(3, 0) == 0); // R9 noise outside EXEC
        end
        in_valid = v; in_unit = 2'(u); in_dst = 3'(d); in_src1 = 3'(s1); in_src2 = 3'(s2);
        fu_done = done;
        #1;
        model_eval(v, u, d);
        sreq = (stall_cause == 3) ? "R3" : (stall_cause == 2) ? "R2" : "R7";
        check(issue_stall == e_stall, sreq, "issue_stall", int'(issue_stall), int'(e_stall));
        check(fu_read_go == e_rd, "R4", "fu_read_go", int'(fu_read_go), int'(e_rd));
        wreq = war_blocked ? "R5" : multi_req ? "R6" : "R9";
        check(fu_write_go == e_wr, wreq, "fu_write_go", int'(fu_write_go), int'(e_wr));
        check(rf_we == e_we, "R6", "rf_we", int'(rf_we), int'(e_we));
        if (e_we) check(int'(rf_waddr) == e_waddr, "R6", "rf_waddr", int'(rf_waddr), e_waddr);
        model_update(u, d, s1, s2, done);
        stalled = e_stall;
    endtask

    task automatic drain(int n);
        bit s;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, s);
    endtask

    task automatic issue_until(int u, int d, int s1, int s2);
        bit s;
        for (int i = 0; i < 200; i++) begin
            step(1, u, d, s1, s2, s);
            if (!s) return;
        end
        check(0, "R7", "issue never accepted", 1, 0);
    endtask

    initial begin
        bit s;
        void'($urandom(32'd2718));
        for (int f = 0; f < 3; f++) begin
            m_st[f] = 0; m_rj[f] = 0; m_rk[f] = 0; m_qjv[f] = 0; m_qkv[f] = 0;
            m_fi[f] = 0; m_fj[f] = 0; m_fk[f] = 0; m_qj[f] = 0; m_qk[f] = 0;
            lat[f] = 0; lat_max[f] = 3;
        end
        for (int r = 0; r < 8; r++) begin m_pv[r] = 0; m_pt[r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        check(issue_stall == 0, "R1", "issue_stall in reset", int'(issue_stall), 0);
        check(fu_read_go == 0, "R1", "fu_read_go in reset", int'(fu_read_go), 0);
        check(fu_write_go == 0, "R1", "fu_write_go in reset", int'(fu_write_go), 0);
        check(rf_we == 0, "R1", "rf_we in reset", int'(rf_we), 0);
        rst_n = 1'b1;
        // R1: first instruction issues at once
        step(1, 0, 3, 1, 2, s);
        check(s == 0, "R1", "first issue stalled", int'(s), 0);
        // R3: same destination on another unit stalls
        step(1, 1, 3, 4, 5, s);
        check(s == 1, "R3", "destination conflict stall", int'(s), 1);
        issue_until(1, 3, 4, 5);
        drain(12);
        // R5 and R8: slow multiply feeds add, fast integer overwrites add's source
        lat_max[2] = 12; lat_max[0] = 0;
        issue_until(2, 2, 6, 7);
        issue_until(1, 1, 2, 5);
        issue_until(0, 5, 6, 7);
        // R2: integer unit now busy
        step(1, 0, 4, 0, 0, s);
        check(s == 1, "R2", "busy unit stall", int'(s), 1);
        issue_until(0, 4, 0, 0);
        drain(40);
        // constrained random phase
        lat_max[0] = 2; lat_max[1] = 4; lat_max[2] = 7;
        begin
            bit v; int u, d, s1, s2;
            s = 0; v = 0; u = 0; d = 0; s1 = 0; s2 = 0;
            for (int i = 0; i < 4000; i++) begin
                if (!s) begin
                    v  = ($urandom_range(9, 0) < 7);
                    u  = $urandom_range(2, 0);
                    d  = $urandom_range(7, 0);
                    s1 = $urandom_range(7, 0);
                    s2 = $urandom_range(7, 0);
                end
                step(v, u, d, s1, s2, s);
            end
        end
        drain(40);
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL R7 watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule